// File: doc/BRIEF.md
# DMA Transfer Length Counter

This block holds the byte count for a host-programmed DMA transfer. The host writes the low and middle bytes of a 16-bit count into staging registers. The staging registers are not visible at the outputs. A command byte whose top bit marks it as a DMA command copies the staged bytes into the live count. If the rest of that command byte is the transfer opcode, the same command also starts a transfer. The length of the transfer is the smaller of two values: the programmed count, and either the size of the pending data or a fixed limit of 32 when the block is capturing a command.

While a transfer runs, the block takes one byte off the remaining count for every byte-moved strobe. When the count reaches zero it pulses `done` and raises terminal count. It also clears the live count bytes, and neighbouring logic uses the `done` pulse to clear its FIFO flags and sequence step. If a new DMA command arrives mid-transfer, the old transfer is dropped without a terminal count.

Top module: `dma_len_counter`

## Requirements
- R1: After a synchronous reset, `remaining` is 0, and `busy`, `done`, `term_cnt`, `to_device`, `live_lo` and `live_mid` are all 0.
- R2: Writes to the staging bytes do not change `live_lo`/`live_mid`. Only a command with bit 7 set copies the staged bytes to the live bytes. A command with bit 7 clear leaves them as they were.
- R3: The programmed count is the low byte plus the middle byte shifted left by 8. A programmed count of 0 stands for 65536 bytes.
- R4: A command whose bit 7 is set and whose bits 6:0 equal 0x10 starts a transfer. Outside capture mode, `remaining` is then loaded with min(count, |pend_size|), where `pend_size` is two's complement. `to_device` is set when `pend_size` is negative.
- R5: With `capture_mode` high, a starting transfer loads min(count, 32) and ignores the magnitude of `pend_size`.
- R6: While busy, each `byte_mv` cycle lowers `remaining` by exactly one. When idle, `byte_mv` has no effect.
- R7: In the cycle where `remaining` first reads 0 after the last byte moves, `done` is high for that cycle only. In the same cycle `term_cnt` is 1, `busy` is 0, and both live bytes read 0.
- R8: A transfer whose effective length is 0 completes straight after its command, with `done` and `term_cnt` set.
- R9: Writing either count byte clears `term_cnt`. If such a write falls in the same cycle as the final byte, the write wins: `term_cnt` stays 0, and `done` still pulses.
- R10: A command with bit 7 set that is not the transfer opcode ends a running transfer: `busy` and `remaining` go to 0, and neither `done` nor `term_cnt` is raised.
- R11: A transfer opcode without bit 7 set starts nothing and leaves `remaining` and `busy` as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_lo | input | 1 | Write `wr_data` to the staged low count byte |
| wr_mid | input | 1 | Write `wr_data` to the staged middle count byte |
| wr_data | input | 8 | Count byte write data |
| cmd_stb | input | 1 | Command byte valid |
| cmd_byte | input | 8 | Command: bit 7 = DMA, bits 6:0 = opcode |
| capture_mode | input | 1 | Command-capture mode (cap length at 32) |
| pend_size | input | PEND_W | Signed pending data size; negative means toward the device |
| byte_mv | input | 1 | One byte moved this cycle |
| remaining | output | 17 | Bytes left in the current transfer |
| live_lo | output | 8 | Live count, low byte |
| live_mid | output | 8 | Live count, middle byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| term_cnt | output | 1 | Terminal-count status |
| to_device | output | 1 | Direction of the current transfer |

## Verification
Two functions collide when the host writes a count byte in the same cycle as the final byte-moved strobe. One clears terminal count and the other sets it. The bench starts a one-byte transfer and then raises `wr_mid` and `byte_mv` together. It then expects `done` high, `term_cnt` low and `remaining` at zero on the next sample. A second overlap is a DMA command that lands in a running transfer; it is judged by `busy` dropping with no `done` pulse.

// File: rtl/dlc_pkg.sv
package dlc_pkg;

    localparam int BYTE_W = 8;
    localparam int LANES  = 2;
    localparam int CNT_W  = BYTE_W * LANES;
    localparam int REM_W  = CNT_W + 1;
    localparam int OP_W   = BYTE_W - 1;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [REM_W-1:0]  rem_t;

    typedef struct packed {
        logic            dma;
        logic [OP_W-1:0] op;
    } cmd_t;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    typedef struct packed {
        logic reload;
        logic start;
        logic abort;
    } ctl_t;

    function automatic ctl_t decode_cmd(input logic stb, input cmd_t c,
                                        input logic [OP_W-1:0] xop);
        ctl_t r;
        r.reload = stb && c.dma;
        r.start  = r.reload && (c.op == xop);
        r.abort  = r.reload && !r.start;
        return r;
    endfunction

endpackage

// File: rtl/dlc_stage.sv
module dlc_stage
    import dlc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] wr_en,
    input  byte_t            wr_data,
    input  logic             reload,
    input  logic             clear,
    output logic [CNT_W-1:0] staged,
    output logic [CNT_W-1:0] live
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        byte_t stg_q;
        byte_t live_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                stg_q <= '0;
            end else if (wr_en[g]) begin
                stg_q <= wr_data;
            end
        end

        // completion zeroes the live byte even when a reload lands with it
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                live_q <= '0;
            end else if (reload) begin
                live_q <= stg_q;
            end
        end

        assign staged[g*BYTE_W +: BYTE_W] = stg_q;
        assign live[g*BYTE_W +: BYTE_W]   = live_q;
    end

    // R2: live bytes move only on reload or completion
    assert_live_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!reload && !clear) |=> $stable(live));

endmodule

// File: rtl/dlc_len_calc.sv
module dlc_len_calc
    import dlc_pkg::*;
#(
    parameter int PEND_W  = 24,
    parameter int CAP_LEN = 32
) (
    input  logic [CNT_W-1:0]  count_raw,
    input  logic [PEND_W-1:0] pend,
    input  logic              capture,
    output rem_t              cnt_full,
    output rem_t              eff,
    output logic              dir
);

    localparam int CMP_W = (REM_W > PEND_W) ? REM_W : PEND_W;

    logic [PEND_W-1:0] mag;
    logic [CMP_W-1:0]  lim;
    logic [CMP_W-1:0]  full_x;

    always_comb begin
        // zero count selects the top bit alone: 2**CNT_W
        cnt_full = {(count_raw == '0), count_raw};
        dir      = pend[PEND_W-1];
        mag      = dir ? (~pend + 1'b1) : pend;
        lim      = capture ? CMP_W'(CAP_LEN) : CMP_W'(mag);
        full_x   = CMP_W'(cnt_full);
        eff      = (full_x < lim) ? cnt_full : REM_W'(lim);
    end

endmodule

// File: rtl/dlc_down.sv
module dlc_down
    import dlc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_t ctl,
    input  rem_t eff,
    input  logic dir_in,
    input  logic byte_mv,
    input  logic tc_clear,
    output rem_t remaining,
    output logic busy,
    output logic done,
    output logic term_cnt,
    output logic to_device,
    output logic finish
);

    phase_e phase_q;
    rem_t   rem_q;
    logic   last_byte;

    assign last_byte = (phase_q == PH_RUN) && byte_mv && (rem_q == rem_t'(1));

    always_comb begin
        if (ctl.start) begin
            finish = (eff == '0);
        end else begin
            finish = !ctl.abort && last_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            rem_q     <= '0;
            done      <= 1'b0;
            to_device <= 1'b0;
        end else begin
            done <= finish;
            if (ctl.start) begin
                rem_q     <= eff;
                to_device <= dir_in;
                phase_q   <= (eff == '0) ? PH_IDLE : PH_RUN;
            end else if (ctl.abort) begin
                rem_q   <= '0;
                phase_q <= PH_IDLE;
            end else if (phase_q == PH_RUN && byte_mv) begin
                rem_q <= rem_q - 1'b1;
                if (last_byte) begin
                    phase_q <= PH_IDLE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            term_cnt <= 1'b0;
        end else if (tc_clear) begin
            term_cnt <= 1'b0;
        end else if (finish) begin
            term_cnt <= 1'b1;
        end else if (ctl.start) begin
            term_cnt <= 1'b0;
        end
    end

    assign remaining = rem_q;
    assign busy      = (phase_q == PH_RUN);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (remaining == '0 && !busy && !term_cnt && !done));

    assert_step_one_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && byte_mv && !ctl.start && !ctl.abort)
            |=> (remaining == $past(remaining) - 1'b1));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy && !ctl.start && !ctl.abort) |=> $stable(remaining));

    assert_done_at_zero_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (remaining == '0 && !busy));

    assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        ctl.abort |=> (!busy && !done && remaining == '0));

endmodule

// File: rtl/dma_len_counter.sv
module dma_len_counter
    import dlc_pkg::*;
#(
    parameter int              PEND_W  = 24,
    parameter int              CAP_LEN = 32,
    parameter logic [OP_W-1:0] XFER_OP = 7'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lo,
    input  logic              wr_mid,
    input  logic [7:0]        wr_data,
    input  logic              cmd_stb,
    input  logic [7:0]        cmd_byte,
    input  logic              capture_mode,
    input  logic [PEND_W-1:0] pend_size,
    input  logic              byte_mv,
    output logic [16:0]       remaining,
    output logic [7:0]        live_lo,
    output logic [7:0]        live_mid,
    output logic              busy,
    output logic              done,
    output logic              term_cnt,
    output logic              to_device
);

    ctl_t             ctl;
    logic [CNT_W-1:0] staged;
    logic [CNT_W-1:0] live;
    rem_t             cnt_full;
    rem_t             eff;
    logic             dir;
    logic             finish;
    logic             tc_clear;

    assign ctl      = decode_cmd(cmd_stb, cmd_t'(cmd_byte), XFER_OP);
    assign tc_clear = wr_lo || wr_mid;

    dlc_stage u_stage (
        .clk     (clk),
        .rst     (rst),
        .wr_en   ({wr_mid, wr_lo}),
        .wr_data (wr_data),
        .reload  (ctl.reload),
        .clear   (finish),
        .staged  (staged),
        .live    (live)
    );

    // the starting command reloads, so its length comes from the staged bytes
    dlc_len_calc #(
        .PEND_W  (PEND_W),
        .CAP_LEN (CAP_LEN)
    ) u_len (
        .count_raw (staged),
        .pend      (pend_size),
        .capture   (capture_mode),
        .cnt_full  (cnt_full),
        .eff       (eff),
        .dir       (dir)
    );

    dlc_down u_down (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .eff       (eff),
        .dir_in    (dir),
        .byte_mv   (byte_mv),
        .tc_clear  (tc_clear),
        .remaining (remaining),
        .busy      (busy),
        .done      (done),
        .term_cnt  (term_cnt),
        .to_device (to_device),
        .finish    (finish)
    );

    assign live_lo  = live[BYTE_W-1:0];
    assign live_mid = live[CNT_W-1:BYTE_W];

    assert_len_bound_R4: assert property (@(posedge clk) disable iff (rst)
        ctl.start |=> (remaining <= $past(cnt_full)));

    assert_cap_limit_R5: assert property (@(posedge clk) disable iff (rst)
        (ctl.start && capture_mode) |=> (remaining <= rem_t'(CAP_LEN)));

    assert_write_clears_tc_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_lo || wr_mid) |=> !term_cnt);

    assert_done_sets_zero_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (live_lo == '0 && live_mid == '0));

endmodule

// File: tb/test_dma_len_counter.sv
`timescale 1ns/1ps
module test_dma_len_counter;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_lo, wr_mid;
    logic [7:0]  wr_data;
    logic        cmd_stb;
    logic [7:0]  cmd_byte;
    logic        capture_mode;
    logic [23:0] pend_size;
    logic        byte_mv;
    logic [16:0] remaining;
    logic [7:0]  live_lo, live_mid;
    logic        busy, done, term_cnt, to_device;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    dma_len_counter i_dma_len_counter (
        .clk (clk), .rst (rst), .wr_lo (wr_lo), .wr_mid (wr_mid),
        .wr_data (wr_data), .cmd_stb (cmd_stb), .cmd_byte (cmd_byte),
        .capture_mode (capture_mode), .pend_size (pend_size),
        .byte_mv (byte_mv), .remaining (remaining), .live_lo (live_lo),
        .live_mid (live_mid), .busy (busy), .done (done),
        .term_cnt (term_cnt), .to_device (to_device)
    );

    // {capture, lo, mid, pend[23:0], expected remaining[16:0], expected dir}
    localparam logic [58:0] VEC [0:7] = '{
        {1'b0, 8'h40, 8'h00, 24'h000064, 17'd64,    1'b0},
        {1'b0, 8'h00, 8'h01, 24'hFFFFCE, 17'd50,    1'b1},
        {1'b0, 8'h00, 8'h00, 24'h011170, 17'd65536, 1'b0},
        {1'b0, 8'h00, 8'h00, 24'hFEEE90, 17'd65536, 1'b1},
        {1'b1, 8'h10, 8'h00, 24'h000000, 17'd16,    1'b0},
        {1'b1, 8'h00, 8'h02, 24'h000005, 17'd32,    1'b0},
        {1'b1, 8'h00, 8'h00, 24'hFFFFFF, 17'd32,    1'b1},
        {1'b0, 8'h34, 8'h12, 24'h001234, 17'h01234, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic put_byte(input logic mid, input logic [7:0] val);
        wr_lo = !mid; wr_mid = mid; wr_data = val;
        cyc();
        wr_lo = 1'b0; wr_mid = 1'b0;
    endtask

    task automatic issue(input logic [7:0] c);
        cmd_stb = 1'b1; cmd_byte = c;
        cyc();
        cmd_stb = 1'b0;
    endtask

    task automatic pulse_byte();
        byte_mv = 1'b1;
        cyc();
        byte_mv = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_lo = 0; wr_mid = 0; wr_data = 0; cmd_stb = 0;
        cmd_byte = 0; capture_mode = 0; pend_size = 0; byte_mv = 0;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        chk("R1 remaining", remaining, 0);
        chk("R1 busy/done/tc/dir", {busy, done, term_cnt, to_device}, 0);
        chk("R1 live", {live_mid, live_lo}, 0);

        // table of length computations (R3, R4, R5)
        for (int i = 0; i < 8; i++) begin
            logic [58:0] v;
            v = VEC[i];
            put_byte(1'b0, v[57:50]);
            put_byte(1'b1, v[49:42]);
            capture_mode = v[58];
            pend_size    = v[41:18];
            issue(8'h90);
            chk("R3/R4/R5 remaining", remaining, v[17:1]);
            chk("R4 to_device", to_device, v[0]);
            chk("R4 busy", busy, 1);
            chk("R2 live reload", {live_mid, live_lo}, {v[49:42], v[57:50]});
        end
        capture_mode = 1'b0;

        // R6 step while busy, then R10 abort by non-transfer DMA command
        pulse_byte();
        pulse_byte();
        chk("R6 two steps", remaining, 17'h01232);
        issue(8'h80);
        chk("R10 abort remaining", remaining, 0);
        chk("R10 abort busy/done/tc", {busy, done, term_cnt}, 0);
        cyc();
        chk("R10 no late done", done, 0);

        // R6 idle strobe ignored
        pulse_byte();
        chk("R6 idle byte_mv", {remaining, done}, 0);

        // R2 staging invisible until DMA command
        put_byte(1'b0, 8'h05);
        chk("R2 write hidden", live_lo, 8'h34);
        issue(8'h00);
        chk("R2 non-DMA command", live_lo, 8'h34);
        issue(8'h80);
        chk("R2 DMA reload", live_lo, 8'h05);

        // R11 transfer opcode without DMA bit
        pend_size = 24'd10;
        issue(8'h10);
        chk("R11 no start", {busy, remaining}, 0);

        // R6/R7 countdown from 3
        put_byte(1'b0, 8'h03);
        put_byte(1'b1, 8'h00);
        issue(8'h90);
        chk("R4 load 3", remaining, 3);
        pulse_byte();
        chk("R6 count 2", remaining, 2);
        pulse_byte();
        chk("R6 count 1", {remaining, done}, {17'd1, 1'b0});
        pulse_byte();
        chk("R7 zero", remaining, 0);
        chk("R7 done/tc/busy", {done, term_cnt, busy}, 3'b110);
        chk("R7 live cleared", {live_mid, live_lo}, 0);
        cyc();
        chk("R7 done one cycle", {done, term_cnt}, 2'b01);

        // R9 byte write clears terminal count
        put_byte(1'b1, 8'h00);
        chk("R9 write clears tc", term_cnt, 0);

        // R8 zero effective length
        put_byte(1'b0, 8'h05);
        pend_size = 24'd0;
        issue(8'h90);
        chk("R8 immediate done/tc/busy", {done, term_cnt, busy}, 3'b110);
        chk("R8 remaining", remaining, 0);

        // R9 write collides with final byte
        put_byte(1'b0, 8'h01);
        pend_size = 24'd10;
        issue(8'h90);
        chk("R9 setup", remaining, 1);
        byte_mv = 1'b1; wr_mid = 1'b1; wr_data = 8'h00;
        cyc();
        byte_mv = 1'b0; wr_mid = 1'b0;
        chk("R9 collision done", {done, remaining}, {1'b1, 17'd0});
        chk("R9 collision tc low", term_cnt, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule